// File: doc/BRIEF.md
# Opcode-Fetch Redirecting Memory Decoder

This block turns the memory-request strobe and the upper address lines of an 8-bit CPU with a 64K map into two active-low chip selects: one for a read-only program store and one for working RAM. Address bit 14 alone chooses between them. The ROM side therefore answers in the 0-16K and 32-48K quarters, and the RAM side answers in the 16-32K and 48-64K quarters. Each select has its own active-high inhibit input. An expansion board drives that input to keep the on-board device quiet while the board serves the access itself.

The block also builds the address bus for the fitted RAM. When a 32K RAM is fitted, RAM address bit 14 comes from CPU A15, so the two RAM quarters reach separate 16K halves of the RAM. The exception is an opcode fetch: while the active-low fetch strobe is asserted, that bit is held at 0. A display fetch aimed above 32K then reads the copy held below 32K. When a smaller RAM is fitted, the upper CPU bits are simply not wired through. The RAM image then repeats through the RAM quarters, and the copy at the lowest address is the primary one. The ROM address is the low CPU bits, so an 8K ROM appears four times.

Everything is combinational. Every output follows the present inputs, and the block holds no state.

Top module: `opfetch_ram_decoder`

## Requirements
- R1: `rom_sel_n` is 0 exactly when `mreq_n` is 0, `cpu_addr[14]` is 0 and `rom_inhibit` is 0. Otherwise it is 1.
- R2: `ram_sel_n` is 0 exactly when `mreq_n` is 0, `cpu_addr[14]` is 1 and `ram_inhibit` is 0. Otherwise it is 1.
- R3: `rom_sel_n` and `ram_sel_n` are never 0 at the same time, for any input combination.
- R4: While `mreq_n` is 1, both selects are 1, whatever the address, fetch strobe and inhibit inputs are.
- R5: `rom_addr` equals `cpu_addr[ROM_AW-1:0]`. With the default ROM_AW of 13, the same ROM byte is therefore addressed at offsets 0, 8K, 32K and 40K.
- R6: With RAM_AW equal to 15 and `m1_n` at 1, `ram_addr[13:0]` equals `cpu_addr[13:0]` and `ram_addr[14]` equals `cpu_addr[15]`. Addresses 16-32K and 48-64K then reach different RAM halves.
- R7: With RAM_AW equal to 15 and `m1_n` at 0, `ram_addr[14]` is 0, so a fetch anywhere in 48-64K reads the byte at the address 32K lower. The low 14 bits still follow `cpu_addr`.
- R8: With RAM_AW below 15, `ram_addr` equals `cpu_addr[RAM_AW-1:0]`, independent of `m1_n`. With RAM_AW of 10 (1K), the image repeats 32 times across the RAM quarters.
- R9: The inhibit inputs affect only their own select. Neither inhibit changes `ram_addr`, `rom_addr` or the other select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mreq_n | input | 1 | CPU memory request, active low |
| m1_n | input | 1 | CPU opcode-fetch strobe, active low |
| cpu_addr | input | CPU_AW (16) | CPU address bus |
| rom_inhibit | input | 1 | External override: forces `rom_sel_n` to 1 |
| ram_inhibit | input | 1 | External override: forces `ram_sel_n` to 1 |
| rom_sel_n | output | 1 | ROM chip select, active low |
| ram_sel_n | output | 1 | RAM chip select, active low |
| rom_addr | output | ROM_AW (13) | Address to the ROM array |
| ram_addr | output | RAM_AW (15) | Address to the RAM array |

## Verification
The hardest case to reach is an opcode fetch into the upper RAM quarter: `m1_n` low, `cpu_addr[15:14]` at 2'b11 and no inhibit. It is the only input combination where the RAM address must differ from the raw CPU bits. The bench drives it with a sweep that crosses every value of the upper address byte with all sixteen strobe and inhibit patterns, and it uses varied low bytes so that the folded address is checked in full. A second instance built for a 1K RAM runs the same vectors to confirm that the fetch strobe has no effect there and that the image repeats.

// File: rtl/odr_pkg.sv
package odr_pkg;

  // Which device window the current bus cycle targets.
  typedef enum logic [1:0] {
    BUS_IDLE = 2'b00,
    BUS_ROM  = 2'b01,
    BUS_RAM  = 2'b10
  } bus_region_e;

  // Address bit that splits the map into ROM and RAM quarters.
  localparam int unsigned REGION_BIT = 14;
  // CPU address bit routed to the RAM's top bit for a full 32K part.
  localparam int unsigned HIGH_WIN_BIT = 15;
  // RAM width at which both RAM quarters reach distinct storage.
  localparam int unsigned FULL_RAM_AW = 15;

endpackage

// File: rtl/odr_region.sv
module odr_region
  import odr_pkg::*;
(
  input  logic        mreq_n,
  input  logic        split_bit,
  output bus_region_e region
);

  always_comb begin
    if (mreq_n)         region = BUS_IDLE;
    else if (split_bit) region = BUS_RAM;
    else                region = BUS_ROM;
  end

endmodule

// File: rtl/odr_select.sv
module odr_select
  import odr_pkg::*;
(
  input  bus_region_e region,
  input  logic        rom_inhibit,
  input  logic        ram_inhibit,
  output logic        rom_sel_n,
  output logic        ram_sel_n
);

  logic rom_hit;
  logic ram_hit;

  assign rom_hit   = (region == BUS_ROM);
  assign ram_hit   = (region == BUS_RAM);
  assign rom_sel_n = ~(rom_hit & ~rom_inhibit);
  assign ram_sel_n = ~(ram_hit & ~ram_inhibit);

endmodule

// File: rtl/odr_ram_map.sv
module odr_ram_map
  import odr_pkg::*;
#(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned RAM_AW = 15
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              m1_n,
  output logic [RAM_AW-1:0] ram_addr
);

  localparam int unsigned LOW_W = FULL_RAM_AW - 1;

  generate
    if (RAM_AW >= FULL_RAM_AW) begin : g_full
      // The top RAM bit picks the half; opcode fetches fold to the lower half.
      logic top_bit;
      assign top_bit  = cpu_addr[HIGH_WIN_BIT] & m1_n;
      assign ram_addr = {top_bit, cpu_addr[LOW_W-1:0]};
      logic unused_full;
      assign unused_full = ^{cpu_addr[CPU_AW-1:HIGH_WIN_BIT+1], cpu_addr[REGION_BIT]};
    end else begin : g_echo
      // Bits above the fitted size are left unconnected: the image repeats.
      assign ram_addr = cpu_addr[RAM_AW-1:0];
      logic unused_echo;
      assign unused_echo = ^{cpu_addr[CPU_AW-1:RAM_AW], m1_n};
    end
  endgenerate

endmodule

// File: rtl/opfetch_ram_decoder.sv
module opfetch_ram_decoder
  import odr_pkg::*;
#(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned ROM_AW = 13,
  parameter int unsigned RAM_AW = 15
) (
  input  logic              mreq_n,
  input  logic              m1_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              rom_inhibit,
  input  logic              ram_inhibit,
  output logic              rom_sel_n,
  output logic              ram_sel_n,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr
);

  bus_region_e region;

  odr_region u_region (
    .mreq_n   (mreq_n),
    .split_bit(cpu_addr[REGION_BIT]),
    .region   (region)
  );

  odr_select u_select (
    .region     (region),
    .rom_inhibit(rom_inhibit),
    .ram_inhibit(ram_inhibit),
    .rom_sel_n  (rom_sel_n),
    .ram_sel_n  (ram_sel_n)
  );

  odr_ram_map #(
    .CPU_AW(CPU_AW),
    .RAM_AW(RAM_AW)
  ) u_ram_map (
    .cpu_addr(cpu_addr),
    .m1_n    (m1_n),
    .ram_addr(ram_addr)
  );

  assign rom_addr = cpu_addr[ROM_AW-1:0];

endmodule

// File: rtl/odr_decoder_chk.sv
module odr_decoder_chk
  import odr_pkg::*;
#(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned RAM_AW = 15
) (
  input logic              mreq_n,
  input logic              m1_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              rom_inhibit,
  input logic              ram_inhibit,
  input logic              rom_sel_n,
  input logic              ram_sel_n,
  input logic [RAM_AW-1:0] ram_addr
);

  always_comb begin
    p_excl_sel_r3: assert (rom_sel_n | ram_sel_n)
      else $error("R3: both selects active");
    p_idle_quiet_r4: assert (!mreq_n || (rom_sel_n && ram_sel_n))
      else $error("R4: select active without memory request");
    p_rom_kill_r1: assert (!rom_inhibit || rom_sel_n)
      else $error("R1: ROM select active while inhibited");
    p_ram_kill_r2: assert (!ram_inhibit || ram_sel_n)
      else $error("R2: RAM select active while inhibited");
    p_ram_needs_hi_r2: assert (ram_sel_n || cpu_addr[REGION_BIT])
      else $error("R2: RAM select in ROM quarter");
    if (RAM_AW >= FULL_RAM_AW) begin
      p_fetch_fold_r7: assert (m1_n || !ram_addr[RAM_AW-1])
        else $error("R7: fetch not folded to lower half");
    end
  end

endmodule

bind opfetch_ram_decoder odr_decoder_chk #(
  .CPU_AW(CPU_AW),
  .RAM_AW(RAM_AW)
) u_chk (
  .mreq_n     (mreq_n),
  .m1_n       (m1_n),
  .cpu_addr   (cpu_addr),
  .rom_inhibit(rom_inhibit),
  .ram_inhibit(ram_inhibit),
  .rom_sel_n  (rom_sel_n),
  .ram_sel_n  (ram_sel_n),
  .ram_addr   (ram_addr)
);

// File: tb/opfetch_ram_decoder_tb.sv
module opfetch_ram_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mreq_n = 1'b1;
  logic        m1_n = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        rom_inhibit = 1'b0;
  logic        ram_inhibit = 1'b0;

  logic        rom_sel_n, ram_sel_n, rom_sel_n_s, ram_sel_n_s;
  logic [12:0] rom_addr, rom_addr_s;
  logic [14:0] ram_addr;
  logic [9:0]  ram_addr_s;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opfetch_ram_decoder u_dut (
    .mreq_n(mreq_n), .m1_n(m1_n), .cpu_addr(cpu_addr),
    .rom_inhibit(rom_inhibit), .ram_inhibit(ram_inhibit),
    .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n),
    .rom_addr(rom_addr), .ram_addr(ram_addr)
  );

  opfetch_ram_decoder #(.RAM_AW(10)) u_dut_1k (
    .mreq_n(mreq_n), .m1_n(m1_n), .cpu_addr(cpu_addr),
    .rom_inhibit(rom_inhibit), .ram_inhibit(ram_inhibit),
    .rom_sel_n(rom_sel_n_s), .ram_sel_n(ram_sel_n_s),
    .rom_addr(rom_addr_s), .ram_addr(ram_addr_s)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h mreq_n=%b m1_n=%b inh=%b%b act=%h exp=%h",
               tag, cpu_addr, mreq_n, m1_n, rom_inhibit, ram_inhibit, act, exp);
    end
  endtask

  // Apply one vector and compare every output against the requirements.
  task automatic apply(logic [15:0] a, logic mq, logic m1, logic rk, logic mk);
    logic exp_rom, exp_ram;
    logic [14:0] exp_big;
    @(negedge clk);
    cpu_addr = a; mreq_n = mq; m1_n = m1; rom_inhibit = rk; ram_inhibit = mk;
    #1;
    vectors++;
    exp_rom = !(!mq && !a[14] && !rk);
    exp_ram = !(!mq && a[14] && !mk);
    exp_big = {a[15] & m1, a[13:0]};
    chk("R1 rom_sel_n", 16'(rom_sel_n), 16'(exp_rom));
    chk("R2 ram_sel_n", 16'(ram_sel_n), 16'(exp_ram));
    chk("R3 exclusive", 16'(rom_sel_n | ram_sel_n), 16'd1);
    if (mq) chk("R4 idle", 16'({rom_sel_n, ram_sel_n}), 16'd3);
    chk("R5 rom_addr", 16'(rom_addr), 16'(a[12:0]));
    if (m1) chk("R6 ram_addr", 16'(ram_addr), 16'(exp_big));
    else    chk("R7 fetch fold", 16'(ram_addr), 16'(exp_big));
    chk("R8 1k ram_addr", 16'(ram_addr_s), 16'(a[9:0]));
    chk("R9 1k rom_sel_n", 16'(rom_sel_n_s), 16'(exp_rom));
    chk("R9 1k ram_sel_n", 16'(ram_sel_n_s), 16'(exp_ram));
  endtask

  task automatic t_reset_state;
    apply(16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R4 reset idle", 16'({rom_sel_n, ram_sel_n}), 16'd3);
  endtask

  task automatic t_sweep;
    for (int hi = 0; hi < 256; hi++)
      for (int s = 0; s < 16; s++)
        apply({8'(hi), 8'((hi * 37 + s * 11) & 8'hFF)}, s[0], s[1], s[2], s[3]);
  endtask

  task automatic t_fold_corners;
    apply(16'hC000, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 fold C000", 16'(ram_addr), 16'h0000);
    apply(16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 fold FFFF", 16'(ram_addr), 16'h3FFF);
    apply(16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 upper half FFFF", 16'(ram_addr), 16'h7FFF);
    apply(16'h4000, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 lower half 4000", 16'(ram_addr), 16'h0000);
  endtask

  task automatic t_echoes;
    apply(16'h8ABC, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R5 rom echo 32K", 16'(rom_addr), 16'h0ABC);
    apply(16'hFC05, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 1k echo top", 16'(ram_addr_s), 16'h0005);
  endtask

  task automatic t_inhibit;
    apply(16'h0100, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 rom inhibit", 16'({rom_sel_n, ram_sel_n}), 16'd3);
    apply(16'hC100, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 other select kept", 16'(ram_sel_n), 16'd0);
    apply(16'hC100, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R9 ram inhibit addr", 16'(ram_addr), 16'h4100);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_sweep();
    t_fold_corners();
    t_echoes();
    t_inhibit();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule